// File: doc/BRIEF.md
# Wavefront Issue Readiness Gate

This block sits beside one wavefront slot of a SIMD scheduler. In every cycle it answers one question: may the instruction at the head of this wavefront's instruction buffer issue to the pipeline class the scheduler is asking about? The answer is a single combinational bit, `issue_ready`. It is formed from the wavefront's run state, the buffer-empty flag, the head opcode class, a barrier stall, free flags for buses and issue slots, free space in the request FIFOs, and an operand-ready flag. The register-file scoreboard and the memory pipelines are outside the block and appear only as input flags.

The block keeps its own memory-traffic bookkeeping. One set of saturating counters tracks requests still inside the issue pipe. A second set tracks requests that have left the pipe and await completion. Each set is split into global read, global write, local read and local write, and a pair of totals counts whole memory instructions. With these counters the block keeps memory operations of one wavefront in order: a read waits for writes of the same space to drain, a write waits for reads, and barrier and return wait until no memory traffic remains.

Encodings. `wf_state`: 0 stopped, 1 running, 2 returning, 3 halted. `req_pipe`: 0 ALU, 1 global, 2 shared, 3 private, 4 flat, 5 to 7 unused. `head_op`: 0 nop, 1 return, 2 branch, 3 vector ALU, 4 barrier, 5/6/7 global read/write/atomic, 8/9/10 shared read/write/atomic, 11/12/13 private read/write/atomic, 14/15 flat read/write. Counter class bits in `disp_cls` and `done_cls`: bit 0 global read, bit 1 global write, bit 2 local read, bit 3 local write.

Top module: `wf_issue_gate`

## Requirements
- R1: `issue_ready` is 0 whenever `wf_state` is not running (1) or `ibuf_empty` is 1.
- R2: A `bar_arrive` pulse sets a barrier stall and captures `bar_cnt_in`. While the stall is set and `grp_all_arrived` is 0, `issue_ready` is 0. In a cycle where the stall is set and `grp_all_arrived` is 1, readiness is evaluated normally, the stall clears at the next edge, and `bar_saved` takes the captured count after that edge.
- R3: In the ALU pipe (0), nop needs only `simd_slot_free`. Branch and vector ALU need `simd_slot_free` and `opnd_ready`. Return and barrier need `simd_slot_free` and zero total memory traffic (in-pipe plus outstanding).
- R4: A global or private read or atomic is not ready while the global write class (in-pipe plus outstanding) is nonzero.
- R5: A global or private write or atomic is not ready while the global read class is nonzero.
- R6: A shared read or atomic is blocked by a nonzero local write class, and a shared write or atomic is blocked by a nonzero local read class. The global classes do not affect shared instructions.
- R7: Global and private instructions need `glb_bus_free`, `glb_slot_free` and `opnd_ready`, and also need `glb_fifo_free` strictly greater than the global read plus write in-pipe counts. Shared instructions need the local equivalents.
- R8: A flat instruction needs both buses, both slots, room in both FIFOs (as in R7) and `opnd_ready`. Flat instructions have no read/write ordering check.
- R9: When `issue` and `issue_ready` are both 1, a memory instruction increments the total in-pipe counter. A read increments its space's read class, a write its write class, and an atomic both. Flat read counts as a global read and flat write as a global write. Nothing is counted when `issue_ready` is 0.
- R10: `disp_cls[i]` moves one request of class i from in-pipe to outstanding, and `disp_any` does the same for the totals; the move does nothing when the in-pipe count is zero. `done_cls[i]` and `done_any` decrement the outstanding counts. Counters saturate at zero and at their maximum, and an increment with a decrement in the same cycle leaves a counter unchanged.
- R11: `issue_ready` is 0 when the pipeline class of `head_op` differs from `req_pipe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wf_state | input | 2 | Wavefront run state |
| ibuf_empty | input | 1 | Instruction buffer is empty |
| head_op | input | 4 | Opcode class of the head instruction |
| req_pipe | input | 3 | Pipeline class being asked about |
| issue | input | 1 | Scheduler issues the head instruction this cycle |
| bar_arrive | input | 1 | Wavefront reached a barrier |
| bar_cnt_in | input | BAR_W | Barrier count captured on arrival |
| grp_all_arrived | input | 1 | Every wavefront of the group is at the barrier |
| simd_slot_free | input | 1 | SIMD issue slot is free |
| glb_bus_free | input | 1 | Register-file-to-global bus is free |
| loc_bus_free | input | 1 | Register-file-to-local bus is free |
| glb_slot_free | input | 1 | Global memory issue slot is free |
| loc_slot_free | input | 1 | Local memory issue slot is free |
| glb_fifo_free | input | FQ_W | Free entries in the global request FIFO |
| loc_fifo_free | input | FQ_W | Free entries in the local request FIFO |
| opnd_ready | input | 1 | Operands and register-file ports are ready |
| disp_cls | input | 4 | Per-class in-pipe to outstanding moves |
| disp_any | input | 1 | Total in-pipe to outstanding move |
| done_cls | input | 4 | Per-class completions |
| done_any | input | 1 | Total completion |
| issue_ready | output | 1 | Head instruction may issue to `req_pipe` |
| bar_saved | output | BAR_W | Barrier count saved when the stall was released |

## Verification
On every cycle, the embedded properties check the following: the run-state and empty-buffer veto, the stall veto during an incomplete barrier, the zero-traffic condition on any ready return or barrier, and the global and local ordering rules against the live counters. In each counter they also check saturation at both ends and the unchanged value when an increment and a decrement coincide. Some behaviour is only visible through the bench's scenarios. This covers whether the right classes are counted for each opcode, whether the in-pipe count feeds the FIFO room test, and whether a saturated decrement stays harmless after a later increment. It also covers whether `bar_saved` receives the count captured at arrival. The bench sweeps all opcode and pipe pairs and every combination of resource flags and FIFO room, and then runs short issue and drain sequences that make the counters visible through `issue_ready`.

// File: rtl/wf_rdy_pkg.sv
package wf_rdy_pkg;

  localparam int NCLS = 4;
  localparam int C_GRD = 0;
  localparam int C_GWR = 1;
  localparam int C_LRD = 2;
  localparam int C_LWR = 3;

  localparam logic [1:0] ST_RUNNING = 2'd1;

  localparam logic [2:0] P_ALU  = 3'd0;
  localparam logic [2:0] P_GLB  = 3'd1;
  localparam logic [2:0] P_SHR  = 3'd2;
  localparam logic [2:0] P_PRV  = 3'd3;
  localparam logic [2:0] P_FLAT = 3'd4;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_RET = 4'd1, OP_BRA = 4'd2, OP_VALU = 4'd3, OP_BAR = 4'd4,
    OP_GRD = 4'd5, OP_GWR = 4'd6, OP_GAT = 4'd7,
    OP_LRD = 4'd8, OP_LWR = 4'd9, OP_LAT = 4'd10,
    OP_PRD = 4'd11, OP_PWR = 4'd12, OP_PAT = 4'd13,
    OP_FRD = 4'd14, OP_FWR = 4'd15
  } wf_op_e;

  function automatic logic [2:0] op_pipe(wf_op_e op);
    case (op)
      OP_GRD, OP_GWR, OP_GAT: return P_GLB;
      OP_LRD, OP_LWR, OP_LAT: return P_SHR;
      OP_PRD, OP_PWR, OP_PAT: return P_PRV;
      OP_FRD, OP_FWR:         return P_FLAT;
      default:                return P_ALU;
    endcase
  endfunction

  // Read-like: must wait for writes of the same space (flat excluded).
  function automatic logic op_read_like(wf_op_e op);
    return op inside {OP_GRD, OP_GAT, OP_LRD, OP_LAT, OP_PRD, OP_PAT};
  endfunction

  function automatic logic op_write_like(wf_op_e op);
    return op inside {OP_GWR, OP_GAT, OP_LWR, OP_LAT, OP_PWR, OP_PAT};
  endfunction

  // Counter classes touched when the instruction issues.
  function automatic logic [NCLS-1:0] op_cls_mask(wf_op_e op);
    logic [NCLS-1:0] m;
    m = '0;
    case (op)
      OP_GRD, OP_PRD, OP_FRD: m[C_GRD] = 1'b1;
      OP_GWR, OP_PWR, OP_FWR: m[C_GWR] = 1'b1;
      OP_GAT, OP_PAT: begin m[C_GRD] = 1'b1; m[C_GWR] = 1'b1; end
      OP_LRD:                 m[C_LRD] = 1'b1;
      OP_LWR:                 m[C_LWR] = 1'b1;
      OP_LAT: begin m[C_LRD] = 1'b1; m[C_LWR] = 1'b1; end
      default: m = '0;
    endcase
    return m;
  endfunction

  // FIFO must hold more free entries than requests already in the pipe.
  function automatic logic fifo_room(int unsigned free_ent, int unsigned in_pipe);
    return free_ent > in_pipe;
  endfunction

endpackage

// File: rtl/wf_sat_ctr.sv
module wf_sat_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic at_zero, at_max;
  assign at_zero = (cnt == '0);
  assign at_max  = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (inc && !dec && !at_max)
      cnt <= cnt + 1'b1;
    else if (dec && !inc && !at_zero)
      cnt <= cnt - 1'b1;
  end

  // R10
  sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && dec && !inc) |=> (cnt == '0));
  // R10
  sat_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && inc && !dec) |=> (cnt == CMAX));
  // R10
  inc_dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));

endmodule

// File: rtl/wf_barrier_track.sv
module wf_barrier_track #(
  parameter int BAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bar_arrive,
  input  logic [BAR_W-1:0] bar_cnt_in,
  input  logic             grp_all_arrived,
  output logic             stall_block,
  output logic [BAR_W-1:0] bar_saved
);
  logic             stalled;
  logic [BAR_W-1:0] bar_cur;
  logic             release_ev;

  assign release_ev  = stalled && grp_all_arrived && !bar_arrive;
  assign stall_block = stalled && !grp_all_arrived;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stalled   <= 1'b0;
      bar_cur   <= '0;
      bar_saved <= '0;
    end else if (bar_arrive) begin
      stalled <= 1'b1;
      bar_cur <= bar_cnt_in;
    end else if (release_ev) begin
      stalled   <= 1'b0;
      bar_saved <= bar_cur;
    end
  end

  // R2
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && !grp_all_arrived) |=> stalled);
  // R2
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !stalled);

endmodule

// File: rtl/wf_issue_decide.sv
module wf_issue_decide
  import wf_rdy_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int FQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             stall_block,
  input  wf_op_e           op,
  input  logic [2:0]       req_pipe,
  input  logic             simd_slot_free,
  input  logic             glb_bus_free,
  input  logic             loc_bus_free,
  input  logic             glb_slot_free,
  input  logic             loc_slot_free,
  input  logic [FQ_W-1:0]  glb_fifo_free,
  input  logic [FQ_W-1:0]  loc_fifo_free,
  input  logic             opnd_ready,
  input  logic [NCLS-1:0]  cls_busy,
  input  logic             traffic,
  input  logic [CNT_W:0]   glb_in_pipe,
  input  logic [CNT_W:0]   loc_in_pipe,
  output logic             ready
);
  logic cls_match, res_ok, order_blk, room_g, room_l;

  assign cls_match = (op_pipe(op) == req_pipe);
  assign room_g = fifo_room(int'(glb_fifo_free), int'(glb_in_pipe));
  assign room_l = fifo_room(int'(loc_fifo_free), int'(loc_in_pipe));

  always_comb begin
    order_blk = 1'b0;
    case (op_pipe(op))
      P_GLB, P_PRV:
        order_blk = (op_read_like(op)  && cls_busy[C_GWR]) ||
                    (op_write_like(op) && cls_busy[C_GRD]);
      P_SHR:
        order_blk = (op_read_like(op)  && cls_busy[C_LWR]) ||
                    (op_write_like(op) && cls_busy[C_LRD]);
      default: order_blk = 1'b0;
    endcase
  end

  always_comb begin
    res_ok = 1'b0;
    case (op_pipe(op))
      P_ALU: begin
        case (op)
          OP_NOP:         res_ok = simd_slot_free;
          OP_RET, OP_BAR: res_ok = simd_slot_free && !traffic;
          default:        res_ok = simd_slot_free && opnd_ready;
        endcase
      end
      P_GLB, P_PRV: res_ok = glb_bus_free && glb_slot_free && room_g && opnd_ready;
      P_SHR:        res_ok = loc_bus_free && loc_slot_free && room_l && opnd_ready;
      P_FLAT:       res_ok = glb_bus_free && loc_bus_free && glb_slot_free &&
                             loc_slot_free && room_g && room_l && opnd_ready;
      default:      res_ok = 1'b0;
    endcase
  end

  assign ready = active && !stall_block && cls_match && res_ok && !order_blk;

  // R3
  drain_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (op == OP_RET || op == OP_BAR)) |-> !traffic);
  // R4
  glb_read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (req_pipe == P_GLB || req_pipe == P_PRV) && op_read_like(op)) |-> !cls_busy[C_GWR]);
  // R5
  glb_write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (req_pipe == P_GLB || req_pipe == P_PRV) && op_write_like(op)) |-> !cls_busy[C_GRD]);
  // R6
  loc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_pipe == P_SHR) |->
      !((op_read_like(op) && cls_busy[C_LWR]) || (op_write_like(op) && cls_busy[C_LRD])));
  // R11
  class_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (op_pipe(op) == req_pipe));

endmodule

// File: rtl/wf_issue_gate.sv
module wf_issue_gate
  import wf_rdy_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int FQ_W  = 4,
  parameter int BAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       wf_state,
  input  logic             ibuf_empty,
  input  logic [3:0]       head_op,
  input  logic [2:0]       req_pipe,
  input  logic             issue,
  input  logic             bar_arrive,
  input  logic [BAR_W-1:0] bar_cnt_in,
  input  logic             grp_all_arrived,
  input  logic             simd_slot_free,
  input  logic             glb_bus_free,
  input  logic             loc_bus_free,
  input  logic             glb_slot_free,
  input  logic             loc_slot_free,
  input  logic [FQ_W-1:0]  glb_fifo_free,
  input  logic [FQ_W-1:0]  loc_fifo_free,
  input  logic             opnd_ready,
  input  logic [3:0]       disp_cls,
  input  logic             disp_any,
  input  logic [3:0]       done_cls,
  input  logic             done_any,
  output logic             issue_ready,
  output logic [BAR_W-1:0] bar_saved
);
  wf_op_e op;
  assign op = wf_op_e'(head_op);

  logic active, stall_block, fire, fire_mem, traffic;
  logic [NCLS-1:0]  inc_mask, move_cls, cls_busy;
  logic [CNT_W-1:0] pipe_cnt [NCLS];
  logic [CNT_W-1:0] outs_cnt [NCLS];
  logic [CNT_W-1:0] tot_pipe, tot_outs;
  logic             tot_move;
  logic [CNT_W:0]   glb_in_pipe, loc_in_pipe;

  assign active   = (wf_state == ST_RUNNING) && !ibuf_empty;
  assign fire     = issue && issue_ready;
  assign inc_mask = fire ? op_cls_mask(op) : '0;
  assign fire_mem = fire && (op_pipe(op) != P_ALU);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign move_cls[c] = disp_cls[c] && (pipe_cnt[c] != '0);
    wf_sat_ctr #(.W(CNT_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .inc(inc_mask[c]), .dec(disp_cls[c]), .cnt(pipe_cnt[c]));
    wf_sat_ctr #(.W(CNT_W)) u_outs (
      .clk(clk), .rst_n(rst_n), .inc(move_cls[c]), .dec(done_cls[c]), .cnt(outs_cnt[c]));
    assign cls_busy[c] = (pipe_cnt[c] != '0) || (outs_cnt[c] != '0);
  end

  assign tot_move = disp_any && (tot_pipe != '0);
  wf_sat_ctr #(.W(CNT_W)) u_tot_pipe (
    .clk(clk), .rst_n(rst_n), .inc(fire_mem), .dec(disp_any), .cnt(tot_pipe));
  wf_sat_ctr #(.W(CNT_W)) u_tot_outs (
    .clk(clk), .rst_n(rst_n), .inc(tot_move), .dec(done_any), .cnt(tot_outs));

  assign traffic     = (tot_pipe != '0) || (tot_outs != '0);
  assign glb_in_pipe = {1'b0, pipe_cnt[C_GRD]} + {1'b0, pipe_cnt[C_GWR]};
  assign loc_in_pipe = {1'b0, pipe_cnt[C_LRD]} + {1'b0, pipe_cnt[C_LWR]};

  wf_barrier_track #(.BAR_W(BAR_W)) u_bar (
    .clk(clk), .rst_n(rst_n), .bar_arrive(bar_arrive), .bar_cnt_in(bar_cnt_in),
    .grp_all_arrived(grp_all_arrived), .stall_block(stall_block), .bar_saved(bar_saved));

  wf_issue_decide #(.CNT_W(CNT_W), .FQ_W(FQ_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .active(active), .stall_block(stall_block), .op(op),
    .req_pipe(req_pipe), .simd_slot_free(simd_slot_free), .glb_bus_free(glb_bus_free),
    .loc_bus_free(loc_bus_free), .glb_slot_free(glb_slot_free), .loc_slot_free(loc_slot_free),
    .glb_fifo_free(glb_fifo_free), .loc_fifo_free(loc_fifo_free), .opnd_ready(opnd_ready),
    .cls_busy(cls_busy), .traffic(traffic), .glb_in_pipe(glb_in_pipe),
    .loc_in_pipe(loc_in_pipe), .ready(issue_ready));

  // R1
  inactive_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_state != ST_RUNNING || ibuf_empty) |-> !issue_ready);
  // R2
  barrier_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_block |-> !issue_ready);
  // R9
  no_count_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_ready && !disp_any && !done_any) |=> $stable(tot_pipe));

endmodule

// File: tb/test_wf_issue_gate.sv
module test_wf_issue_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] wf_state = 2'd0;
  logic ibuf_empty = 1'b0;
  logic [3:0] head_op = 4'd0;
  logic [2:0] req_pipe = 3'd0;
  logic issue = 1'b0, bar_arrive = 1'b0, grp_all_arrived = 1'b0;
  logic [7:0] bar_cnt_in = 8'd0;
  logic simd_slot_free = 1'b1, glb_bus_free = 1'b1, loc_bus_free = 1'b1;
  logic glb_slot_free = 1'b1, loc_slot_free = 1'b1, opnd_ready = 1'b1;
  logic [3:0] glb_fifo_free = 4'd4, loc_fifo_free = 4'd4;
  logic [3:0] disp_cls = 4'd0, done_cls = 4'd0;
  logic disp_any = 1'b0, done_any = 1'b0;
  logic issue_ready;
  logic [7:0] bar_saved;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wf_issue_gate i_wf_issue_gate (
    .clk(clk), .rst_n(rst_n), .wf_state(wf_state), .ibuf_empty(ibuf_empty),
    .head_op(head_op), .req_pipe(req_pipe), .issue(issue), .bar_arrive(bar_arrive),
    .bar_cnt_in(bar_cnt_in), .grp_all_arrived(grp_all_arrived),
    .simd_slot_free(simd_slot_free), .glb_bus_free(glb_bus_free),
    .loc_bus_free(loc_bus_free), .glb_slot_free(glb_slot_free),
    .loc_slot_free(loc_slot_free), .glb_fifo_free(glb_fifo_free),
    .loc_fifo_free(loc_fifo_free), .opnd_ready(opnd_ready), .disp_cls(disp_cls),
    .disp_any(disp_any), .done_cls(done_cls), .done_any(done_any),
    .issue_ready(issue_ready), .bar_saved(bar_saved));

  function automatic int pipe_of(int op);
    if (op <= 4) return 0;
    if (op <= 7) return 1;
    if (op <= 10) return 2;
    if (op <= 13) return 3;
    return 4;
  endfunction

  // Expected readiness with all counters at zero and no barrier stall.
  function automatic bit exp_idle(int op, int rq, bit sf, bit gb, bit lb, bit gs,
                                  bit ls, bit od, int gf, int lf);
    int p = pipe_of(op);
    if (p != rq) return 0;
    case (p)
      0: if (op == 0 || op == 1 || op == 4) return sf; else return sf & od;
      1, 3: return gb & gs & (gf > 0) & od;
      2: return lb & ls & (lf > 0) & od;
      default: return gb & lb & gs & ls & (gf > 0) & (lf > 0) & od;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (op=%0d pipe=%0d)", req, act, exp,
               head_op, req_pipe);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ask(input int op, input int rq, input logic exp, input string req);
    head_op = op[3:0];
    req_pipe = rq[2:0];
    #1;
    chk(issue_ready, exp, req);
  endtask

  task automatic issue_op(input int op);
    head_op = op[3:0];
    req_pipe = 3'(pipe_of(op));
    #1;
    chk(issue_ready, 1'b1, "R9 issue precondition");
    issue = 1'b1;
    step();
    issue = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] dc, input logic da, input logic [3:0] fc,
                       input logic fa);
    disp_cls = dc; disp_any = da; done_cls = fc; done_any = fa;
    step();
    disp_cls = '0; disp_any = 1'b0; done_cls = '0; done_any = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    #1;
    // Reset state: stopped wavefront, nothing ready, saved count zero.
    chk(issue_ready, 1'b0, "R1 reset state");
    chk(bar_saved == 8'd0, 1'b1, "R2 reset bar_saved");

    // R1: state and empty-buffer sweep.
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++) begin
        wf_state = s[1:0];
        ibuf_empty = e[0];
        ask(3, 0, (s == 1) && (e == 0), "R1 state/empty");
      end
    wf_state = 2'd1;
    ibuf_empty = 1'b0;

    // R11: every opcode against every pipe request, all resources free.
    for (int op = 0; op < 16; op++)
      for (int rq = 0; rq < 8; rq++)
        ask(op, rq, pipe_of(op) == rq, "R11 class match");

    // R3 R7 R8: all resource combinations and FIFO room at empty pipe.
    for (int op = 0; op < 16; op++)
      for (int v = 0; v < 64; v++)
        for (int f = 0; f < 4; f++) begin
          simd_slot_free = v[0]; glb_bus_free = v[1]; loc_bus_free = v[2];
          glb_slot_free = v[3]; loc_slot_free = v[4]; opnd_ready = v[5];
          glb_fifo_free = f[0] ? 4'd1 : 4'd0;
          loc_fifo_free = f[1] ? 4'd1 : 4'd0;
          ask(op, pipe_of(op), exp_idle(op, pipe_of(op), v[0], v[1], v[2], v[3], v[4],
              v[5], f[0], f[1]), "R3/R7/R8 resources");
        end
    simd_slot_free = 1; glb_bus_free = 1; loc_bus_free = 1;
    glb_slot_free = 1; loc_slot_free = 1; opnd_ready = 1;
    glb_fifo_free = 4'd4; loc_fifo_free = 4'd4;

    // R9 R4 R5 R7 R3: one global read in the pipe.
    issue_op(5);
    ask(6, 1, 1'b0, "R5 write behind in-pipe read");
    ask(7, 1, 1'b0, "R5 atomic behind read");
    ask(12, 3, 1'b0, "R5 private write behind read");
    ask(1, 0, 1'b0, "R3 return waits for traffic");
    ask(4, 0, 1'b0, "R3 barrier waits for traffic");
    ask(0, 0, 1'b1, "R3 nop ignores traffic");
    ask(9, 2, 1'b1, "R6 local write ignores global reads");
    glb_fifo_free = 4'd1;
    ask(5, 1, 1'b0, "R7 fifo room vs in-pipe count");
    glb_fifo_free = 4'd2;
    ask(5, 1, 1'b1, "R7 fifo room vs in-pipe count");
    glb_fifo_free = 4'd4;
    pulse(4'b0001, 1'b1, 4'b0000, 1'b0);
    ask(6, 1, 1'b0, "R10 outstanding read still blocks write");
    ask(1, 0, 1'b0, "R10 outstanding still blocks return");
    pulse(4'b0000, 1'b0, 4'b0001, 1'b1);
    ask(6, 1, 1'b1, "R10 completion unblocks write");
    ask(1, 0, 1'b1, "R3 return after drain");

    // R9 R6: shared atomic counts both local classes.
    issue_op(10);
    ask(8, 2, 1'b0, "R6 local read behind atomic");
    ask(9, 2, 1'b0, "R6 local write behind atomic");
    ask(5, 1, 1'b1, "R6 global unaffected by local");
    pulse(4'b1100, 1'b1, 4'b0000, 1'b0);
    pulse(4'b0000, 1'b0, 4'b1100, 1'b1);
    ask(8, 2, 1'b1, "R10 local drained");
    ask(4, 0, 1'b1, "R10 barrier after local drain");

    // R10: decrement at zero saturates.
    pulse(4'b0010, 1'b1, 4'b0010, 1'b1);
    issue_op(6);
    ask(5, 1, 1'b0, "R4 read behind in-pipe write");
    ask(11, 3, 1'b0, "R4 private read behind write");
    // Issue a second write while one moves out: in-pipe stays 1.
    head_op = 4'd6; req_pipe = 3'd1;
    disp_cls = 4'b0010; disp_any = 1'b1; issue = 1'b1;
    #1;
    chk(issue_ready, 1'b1, "R10 second write ready");
    step();
    issue = 1'b0; disp_cls = '0; disp_any = 1'b0;
    pulse(4'b0010, 1'b1, 4'b0000, 1'b0);
    pulse(4'b0000, 1'b0, 4'b0010, 1'b1);
    ask(5, 1, 1'b0, "R10 inc+dec kept in-pipe count");
    pulse(4'b0000, 1'b0, 4'b0010, 1'b1);
    ask(5, 1, 1'b1, "R10 all writes drained");
    ask(1, 0, 1'b1, "R10 totals drained");

    // R8 R9: flat read counts as global read but has no ordering.
    issue_op(14);
    ask(6, 1, 1'b0, "R9 flat read counted as global read");
    ask(15, 4, 1'b1, "R8 flat write has no ordering");
    glb_fifo_free = 4'd1;
    ask(14, 4, 1'b0, "R8 flat needs global fifo room");
    glb_fifo_free = 4'd4;
    pulse(4'b0001, 1'b1, 4'b0000, 1'b0);
    pulse(4'b0000, 1'b0, 4'b0001, 1'b1);
    ask(6, 1, 1'b1, "R9 flat read drained");

    // R9: an issue strobe while not ready counts nothing.
    wf_state = 2'd0;
    head_op = 4'd5; req_pipe = 3'd1; issue = 1'b1;
    step();
    issue = 1'b0;
    wf_state = 2'd1;
    ask(6, 1, 1'b1, "R9 no count when not ready");

    // R2: barrier stall and release.
    bar_cnt_in = 8'd5;
    bar_arrive = 1'b1;
    step();
    bar_arrive = 1'b0;
    bar_cnt_in = 8'd9;
    ask(3, 0, 1'b0, "R2 stalled at barrier");
    step();
    ask(3, 0, 1'b0, "R2 still stalled");
    chk(bar_saved == 8'd0, 1'b1, "R2 saved count before release");
    grp_all_arrived = 1'b1;
    ask(3, 0, 1'b1, "R2 ready when group arrived");
    step();
    chk(bar_saved == 8'd5, 1'b1, "R2 saved count after release");
    grp_all_arrived = 1'b0;
    ask(3, 0, 1'b1, "R2 stall cleared");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule